// File: doc/BRIEF.md
# UART Modem Control and Loopback

This block holds the 8-bit modem-control byte of one UART channel and turns it into the channel's outward behaviour. A simple write strobe with a data byte updates the register, and the current value is always readable. From the byte the block drives the active-low DTR, RTS and general-purpose output pins. It selects whether the baud logic downstream advances on every input clock or on one clock in four. It also exports three enables: access to the flow-trigger registers, any-character resume of transmission, and the FIFO-ready status register.

The three top bits are protected. They accept a write only while the enhanced-features unlock input is high. When hardware flow control is active, the RTS pin follows the flow-control request and ignores the register bit.

Setting the loopback bit folds the channel back on itself. The transmit stream feeds the receive stream, and the external transmit pin idles high. The external modem pins go inactive, and the status nibble seen by the receiver is built from four of the control bits instead of the external status pins.

Top module: `uart_modem_ctl`

## Requirements
- R1: A synchronous active-high reset clears the control byte to 0x00. During and after reset, dtr_n, rts_n, op_n and tx_pin are high, and baud_ce is high on every cycle.
- R2: With wr_en high at a clock edge, bits 4..0 of wr_data are stored regardless of efr_unlock. rd_data shows the stored byte from the next cycle.
- R3: Bits 7..5 are stored on a write only when efr_unlock is high; otherwise they keep their previous value.
- R4: Outside loopback, with auto_rts_en low, rts_n is the inverse of bit 1, dtr_n the inverse of bit 0 and op_n the inverse of bit 3.
- R5: Outside loopback, with auto_rts_en high, rts_n is the inverse of auto_rts_req and bit 1 has no effect on it.
- R6: With bit 7 at 0, baud_ce is high every cycle. With bit 7 at 1, baud_ce is high only when a free-running 2-bit counter is at 3. That counter is 0 in the first cycle after reset is released and advances by one each cycle.
- R7: trig_access_en equals bit 6, xon_any_en equals bit 5, and fifo_rdy_en equals bit 2.
- R8: Bit 4 selects loopback. When it is 1, rx_ser equals tx_ser and tx_pin is high. When it is 0, rx_ser equals rx_pin and tx_pin equals tx_ser.
- R9: In loopback, dtr_n, rts_n and op_n are high whatever the control bits and auto-RTS inputs are.
- R10: status_nib[3..0] stands for modem-status bits 7..4. In loopback it is {bit 3, bit 2, bit 0, bit 1} and ext_status is ignored. Outside loopback it equals ext_status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Byte to write |
| efr_unlock | input | 1 | Write enable for bits 7..5 |
| rd_data | output | 8 | Current control byte |
| auto_rts_en | input | 1 | Hardware flow control owns RTS |
| auto_rts_req | input | 1 | Flow-control request, 1 = assert RTS |
| tx_ser | input | 1 | Serial stream from the transmitter |
| rx_pin | input | 1 | Serial line from the external pin |
| ext_status | input | 4 | External modem status, bits 7..4 |
| tx_pin | output | 1 | Serial line to the external pin |
| rx_ser | output | 1 | Serial stream to the receiver |
| status_nib | output | 4 | Modem status bits 7..4 to the status register |
| dtr_n | output | 1 | DTR pin, active low |
| rts_n | output | 1 | RTS pin, active low |
| op_n | output | 1 | General-purpose output pin, active low |
| trig_access_en | output | 1 | Enables trigger-register access |
| xon_any_en | output | 1 | Enables any-character resume |
| fifo_rdy_en | output | 1 | Enables the FIFO-ready register |
| baud_ce | output | 1 | Clock enable for the baud logic |

## Verification
The bench builds the block with its default prescale ratio of four, so the divided enable is a 2-bit count. Every phase of that count lines up with writes that switch bit 7 on and off within a few hundred cycles. Random writes mix locked and unlocked cycles with loopback on and off, and auto-RTS on and off. This exercises protected-bit retention, the crossed bit 0/bit 1 mapping in the status nibble, and loopback overriding auto-RTS against a reference model on every cycle.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    localparam int CTRL_W = 8;
    // Bits that need the unlock input to change
    localparam logic [CTRL_W-1:0] PROT_MASK = 8'hE0;

    typedef struct packed {
        logic clk_div4;     // 7
        logic trig_access;  // 6
        logic xon_any;      // 5
        logic loop_en;      // 4
        logic op_ctl;       // 3
        logic fifo_rdy;     // 2
        logic rts_ctl;      // 1
        logic dtr_ctl;      // 0
    } mcr_t;

    typedef struct packed {
        logic tx_pin;
        logic rx_ser;
        logic dtr_n;
        logic rts_n;
        logic op_n;
        logic [3:0] status_nib;
    } pin_bundle_t;

    // Status bits 7..4 produced in loopback
    function automatic logic [3:0] loop_status(input mcr_t c);
        return {c.op_ctl, c.fifo_rdy, c.dtr_ctl, c.rts_ctl};
    endfunction

    // Merge a write with the held value under the protection mask
    function automatic logic [CTRL_W-1:0] merge_write(
        input logic [CTRL_W-1:0] held,
        input logic [CTRL_W-1:0] wdat,
        input logic              unlock);
        logic [CTRL_W-1:0] keep;
        keep = unlock ? '0 : PROT_MASK;
        return (held & keep) | (wdat & ~keep);
    endfunction

endpackage

// File: rtl/mcr_reg.sv
module mcr_reg
    import mcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              unlock,
    output mcr_t              ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= mcr_t'(merge_write(ctrl, wr_data, unlock));
        end
    end

    // R3: locked writes leave the protected bits alone
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !unlock) |=> (ctrl[7:5] == $past(ctrl[7:5])));

    // R2: low bits always take the written value
    p_low_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl[4:0] == $past(wr_data[4:0])));

endmodule

// File: rtl/mcr_prescale.sv
module mcr_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic div_sel,
    output logic ce
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    generate
        if (DIV <= 1) begin : g_pass
            assign ce = 1'b1;
        end else begin : g_div
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || cnt == LAST) cnt <= '0;
                else                   cnt <= cnt + 1'b1;
            end
            assign ce = div_sel ? (cnt == LAST) : 1'b1;

            // R6: divided enable never fires on two cycles in a row
            p_ce_gap_r6: assert property (@(posedge clk) disable iff (rst)
                (div_sel && ce) |=> (!ce || !div_sel));
        end
    endgenerate

endmodule

// File: rtl/mcr_pinmux.sv
module mcr_pinmux
    import mcr_pkg::*;
(
    input  mcr_t        ctrl,
    input  logic        auto_rts_en,
    input  logic        auto_rts_req,
    input  logic        tx_ser,
    input  logic        rx_pin,
    input  logic [3:0]  ext_status,
    output pin_bundle_t pins
);

    always_comb begin
        if (ctrl.loop_en) begin
            pins.tx_pin     = 1'b1;
            pins.rx_ser     = tx_ser;
            pins.dtr_n      = 1'b1;
            pins.rts_n      = 1'b1;
            pins.op_n       = 1'b1;
            pins.status_nib = loop_status(ctrl);
        end else begin
            pins.tx_pin     = tx_ser;
            pins.rx_ser     = rx_pin;
            pins.dtr_n      = ~ctrl.dtr_ctl;
            pins.rts_n      = auto_rts_en ? ~auto_rts_req : ~ctrl.rts_ctl;
            pins.op_n       = ~ctrl.op_ctl;
            pins.status_nib = ext_status;
        end
    end

endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl #(
    parameter int PRESCALE_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       efr_unlock,
    output logic [7:0] rd_data,
    input  logic       auto_rts_en,
    input  logic       auto_rts_req,
    input  logic       tx_ser,
    input  logic       rx_pin,
    input  logic [3:0] ext_status,
    output logic       tx_pin,
    output logic       rx_ser,
    output logic [3:0] status_nib,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       op_n,
    output logic       trig_access_en,
    output logic       xon_any_en,
    output logic       fifo_rdy_en,
    output logic       baud_ce
);
    import mcr_pkg::*;

    mcr_t        ctrl;
    pin_bundle_t pins;

    mcr_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .unlock  (efr_unlock),
        .ctrl    (ctrl)
    );

    mcr_prescale #(.DIV(PRESCALE_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .div_sel (ctrl.clk_div4),
        .ce      (baud_ce)
    );

    mcr_pinmux u_mux (
        .ctrl         (ctrl),
        .auto_rts_en  (auto_rts_en),
        .auto_rts_req (auto_rts_req),
        .tx_ser       (tx_ser),
        .rx_pin       (rx_pin),
        .ext_status   (ext_status),
        .pins         (pins)
    );

    assign rd_data        = ctrl;
    assign tx_pin         = pins.tx_pin;
    assign rx_ser         = pins.rx_ser;
    assign status_nib     = pins.status_nib;
    assign dtr_n          = pins.dtr_n;
    assign rts_n          = pins.rts_n;
    assign op_n           = pins.op_n;
    assign trig_access_en = ctrl.trig_access;
    assign xon_any_en     = ctrl.xon_any;
    assign fifo_rdy_en    = ctrl.fifo_rdy;

    // R9: loopback keeps all modem pins inactive
    p_loop_pins_high_r9: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> (dtr_n && rts_n && op_n));

    // R8: loopback idles the line and feeds the receiver from the transmitter
    p_loop_serial_r8: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> (tx_pin && rx_ser == tx_ser));

    // R10: crossed mapping of bits 1/0 into the status nibble
    p_loop_map_r10: assert property (@(posedge clk) disable iff (rst)
        rd_data[4] |-> (status_nib[1] == rd_data[0] && status_nib[0] == rd_data[1]));

    // R5: hardware flow control owns RTS outside loopback
    p_auto_rts_r5: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[4] && auto_rts_en) |-> (rts_n == !auto_rts_req));

endmodule

// File: tb/sim_uart_modem_ctl.sv
module sim_uart_modem_ctl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       efr_unlock = 1'b0;
    logic       auto_rts_en = 1'b0;
    logic       auto_rts_req = 1'b0;
    logic       tx_ser = 1'b1;
    logic       rx_pin = 1'b1;
    logic [3:0] ext_status = 4'h0;
    logic [7:0] rd_data;
    logic       tx_pin, rx_ser, dtr_n, rts_n, op_n;
    logic       trig_access_en, xon_any_en, fifo_rdy_en, baud_ce;
    logic [3:0] status_nib;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    // Reference state
    logic [7:0] m_ctrl = 8'h00;
    int         m_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    uart_modem_ctl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .efr_unlock(efr_unlock), .rd_data(rd_data),
        .auto_rts_en(auto_rts_en), .auto_rts_req(auto_rts_req),
        .tx_ser(tx_ser), .rx_pin(rx_pin), .ext_status(ext_status),
        .tx_pin(tx_pin), .rx_ser(rx_ser), .status_nib(status_nib),
        .dtr_n(dtr_n), .rts_n(rts_n), .op_n(op_n),
        .trig_access_en(trig_access_en), .xon_any_en(xon_any_en),
        .fifo_rdy_en(fifo_rdy_en), .baud_ce(baud_ce)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model update on each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_ctrl <= 8'h00;
            m_cnt  <= 0;
        end else begin
            m_cnt <= (m_cnt + 1) % 4;
            if (wr_en) begin
                m_ctrl[4:0] <= wr_data[4:0];
                if (efr_unlock) m_ctrl[7:5] <= wr_data[7:5];
            end
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic loop;
            loop = m_ctrl[4];
            if (rst) chk("R1", "reset ctrl", rd_data, 8'h00);
            else     chk("R2", "rd_data", rd_data, m_ctrl);
            chk("R6", "baud_ce", {7'd0, baud_ce},
                {7'd0, (m_ctrl[7] ? (m_cnt == 3) : 1'b1)});
            chk("R7", "enables", {5'd0, trig_access_en, xon_any_en, fifo_rdy_en},
                {5'd0, m_ctrl[6], m_ctrl[5], m_ctrl[2]});
            chk("R8", "serial", {6'd0, tx_pin, rx_ser},
                {6'd0, (loop ? 1'b1 : tx_ser), (loop ? tx_ser : rx_pin)});
            if (loop) begin
                chk("R9", "loop pins", {5'd0, dtr_n, rts_n, op_n}, 8'h07);
                chk("R10", "loop nibble", {4'd0, status_nib},
                    {4'd0, m_ctrl[3], m_ctrl[2], m_ctrl[0], m_ctrl[1]});
            end else begin
                chk("R4", "dtr/op", {6'd0, dtr_n, op_n}, {6'd0, ~m_ctrl[0], ~m_ctrl[3]});
                if (auto_rts_en)
                    chk("R5", "auto rts", {7'd0, rts_n}, {7'd0, ~auto_rts_req});
                else
                    chk("R4", "rts", {7'd0, rts_n}, {7'd0, ~m_ctrl[1]});
                chk("R10", "ext nibble", {4'd0, status_nib}, {4'd0, ext_status});
            end
        end
    end

    task automatic cyc(input logic we, input logic [7:0] d, input logic ul);
        @(negedge clk);
        #1;
        wr_en = we; wr_data = d; efr_unlock = ul;
        tx_ser = $urandom_range(0, 1);
        rx_pin = $urandom_range(0, 1);
        ext_status = 4'($urandom_range(0, 15));
        auto_rts_req = $urandom_range(0, 1);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
                done = 1;
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none
        repeat (3) @(posedge clk);
        // R1: pins idle while reset is held
        @(negedge clk);
        chk("R1", "reset pins", {4'd0, dtr_n, rts_n, op_n, tx_pin}, 8'h0F);
        #1 rst = 1'b0;
        // R3: locked write keeps top bits at 0
        cyc(1'b1, 8'hFF, 1'b0);
        cyc(1'b0, 8'h00, 1'b0);
        // unlocked write with divide-by-4, loopback off
        cyc(1'b1, 8'h8B, 1'b1);
        repeat (8) cyc(1'b0, 8'h00, 1'b0);
        // loopback with crossed bits, then auto-RTS
        cyc(1'b1, 8'h11, 1'b0);
        repeat (4) cyc(1'b0, 8'h00, 1'b0);
        cyc(1'b1, 8'h12, 1'b0);
        auto_rts_en = 1'b1;
        repeat (4) cyc(1'b0, 8'h00, 1'b0);
        cyc(1'b1, 8'h02, 1'b0);
        repeat (4) cyc(1'b0, 8'h00, 1'b0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            if (i % 97 == 0) auto_rts_en = $urandom_range(0, 1);
            cyc($urandom_range(0, 3) == 0, 8'($urandom_range(0, 255)),
                $urandom_range(0, 1));
        end
        // Reset from a non-zero state
        cyc(1'b1, 8'hFF, 1'b1);
        cyc(1'b0, 8'h00, 1'b0);
        rst = 1'b1;
        repeat (2) cyc(1'b0, 8'h00, 1'b0);
        @(negedge clk);
        chk("R1", "re-reset ctrl", rd_data, 8'h00);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule